// File: doc/BRIEF.md
# DRAM Pad Impedance Calibration Sequencer

This block is a hardware state machine that sets up the output drive and termination impedance of a DRAM controller's pads at start of day. A single start strobe begins the sequence. The block then runs it through a small register master that reaches four controller registers: impedance control, impedance status, auxiliary control and pad I/O configuration. The analog calibration engine and the pads themselves sit behind those registers and are not part of this block.

On start, the block captures a 32-bit impedance word, a 2-bit on-die-termination (ODT) enable and two variant inputs. It may first wait for a calibration already in progress. If termination is disabled it stops there. Otherwise it clears the calibration-start bit and then takes one of two paths. If the packed data field of the impedance word is non-zero, that data is loaded directly. If the field is zero, a resistor calibration is run with the packed divisors and the block polls until it completes. The block then clears the start bit again and finally writes the termination enables to the I/O configuration register. Every status poll is bounded by a programmable cycle limit. When the limit runs out, the sequence is aborted with an error pulse.

Top module: `zq_cal_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `reg_req` are all low.
- R2: A `start` pulse in idle captures `imp_param`, `odt_en`, `aux_variant` and `pre_wait`; a `start` while `busy` is high is ignored and does not change the writes that follow.
- R3: Once `reg_req` is raised, it stays high with `reg_addr`, `reg_we` and `reg_wdata` unchanged until `reg_ack`; each `reg_ack` completes exactly one access. Addresses are: 0 control, 1 status, 2 auxiliary, 3 I/O configuration.
- R4: With `pre_wait` high, the sequence starts by reading status (address 1) until bit 31 reads 1, and only then issues any write.
- R5: With `odt_en` equal to 0, no register write is issued; `done` pulses once the optional pre-wait is over.
- R6: With `aux_variant` high and `odt_en` non-zero, the first write is 0x0100_0002 (bits 24 and 1) to address 2, and it comes before any control write.
- R7: Before the load or calibration step, control is read and written back with bit 31 cleared and all other bits kept.
- R8: If `imp_param[27:8]` is non-zero, control is written with bit 28 set and that 20-bit value in bits 19:0; no status poll follows.
- R9: If `imp_param[27:8]` is zero, control is written with bit 31 set and `imp_param[7:0]` in bits 27:20; status is then polled until bit 31 reads 1. Bits 31:28 of `imp_param` have no effect.
- R10: After the load or calibration step, control is again read and written back with bit 31 cleared.
- R11: The last write goes to address 3 and carries `odt_en` in both bits 31:30 and bits 1:0, with all other bits zero. The cycle after its acknowledge, `done` is high for one cycle and `busy` is low.
- R12: If a status poll has run for `poll_limit` cycles without reading bit 31 set, `err` pulses for one cycle, `busy` falls, `done` stays low and no further write is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, one cycle |
| imp_param | input | 32 | Impedance word: divisors in 7:0, fixed data in 27:8 |
| odt_en | input | 2 | Termination enable: bit 0 data lines, bit 1 strobe lines |
| aux_variant | input | 1 | Selects the variant that needs the auxiliary write |
| pre_wait | input | 1 | Selects the variant that waits for a default calibration first |
| poll_limit | input | 16 | Cycle limit for each status poll |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 for write, 0 for read |
| reg_addr | output | 2 | Register select |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | One-cycle acknowledge from the register slave |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on poll timeout |

## Verification
The assertions assume a register slave that raises `reg_ack` only as a single-cycle reply to a pending request, and that never acknowledges while `reg_req` is low. They also assume the slave returns read data in the same cycle as the acknowledge. The bench's slave model acknowledges one cycle after it sees a request, drops the acknowledge for a cycle before it serves the next one, and is reinitialised between scenarios. The `start` pulse is always driven at the falling edge so it is seen at exactly one rising edge. A stray acknowledge after a timeout abort reaches the block only while it is idle, where it is ignored.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int DIV_W   = 8;
    localparam int DATA_W  = 20;
    localparam int DATA_LO = 8;
    localparam int DIV_LSB = 20;
    localparam int BIT_CAL = 31;
    localparam int BIT_SEL = 28;
    localparam int BIT_FLG = 31;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_AUX  = 2'd2;
    localparam logic [ADDR_W-1:0] A_IO   = 2'd3;

    localparam logic [REG_W-1:0] AUX_WORD = (32'd1 << 24) | (32'd1 << 1);

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE_POLL, ST_AUX_WR, ST_CLR1_RD, ST_CLR1_WR,
        ST_LOAD_WR, ST_CAL_WR, ST_CAL_POLL, ST_CLR2_RD, ST_CLR2_WR, ST_IO_WR
    } seq_state_e;
endpackage

// File: rtl/zq_cal_field_split.sv
module zq_cal_field_split
    import zq_cal_pkg::*;
(
    input  logic [REG_W-1:0] imp_word,
    output logic             use_data,
    output logic [REG_W-1:0] load_word,
    output logic [REG_W-1:0] cal_word
);
    logic [DIV_W-1:0]  div_f;
    logic [DATA_W-1:0] data_f;

    always_comb begin
        div_f     = imp_word[DIV_W-1:0];
        data_f    = imp_word[DATA_LO +: DATA_W];
        use_data  = |data_f;
        load_word = '0;
        load_word[BIT_SEL]      = 1'b1;
        load_word[DATA_W-1:0]   = data_f;
        cal_word  = '0;
        cal_word[BIT_CAL]              = 1'b1;
        cal_word[DIV_LSB +: DIV_W]     = div_f;
    end
endmodule

// File: rtl/zq_cal_poll_timer.sv
module zq_cal_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) cnt_d = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/zq_cal_seq.sv
module zq_cal_seq
    import zq_cal_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       imp_param,
    input  logic [1:0]        odt_en,
    input  logic              aux_variant,
    input  logic              pre_wait,
    input  logic [TMO_W-1:0]  poll_limit,
    output logic              reg_req,
    output logic              reg_we,
    output logic [1:0]        reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [31:0]       reg_rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        seq_state_e       state;
        logic [REG_W-1:0] imp;
        logic [1:0]       odt;
        logic             aux;
        logic [REG_W-1:0] rmw;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t d, q;

    logic             use_data;
    logic [REG_W-1:0] load_word, cal_word;
    logic             polling, expired, flag_seen;

    zq_cal_field_split u_split (
        .imp_word (q.imp),
        .use_data (use_data),
        .load_word(load_word),
        .cal_word (cal_word)
    );

    assign polling = (q.state == ST_PRE_POLL) || (q.state == ST_CAL_POLL);

    zq_cal_poll_timer #(.TMO_W(TMO_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (polling),
        .limit  (poll_limit),
        .expired(expired)
    );

    assign flag_seen = reg_ack && reg_rdata[BIT_FLG];

    function automatic seq_state_e after_pre(logic [1:0] o, logic a);
        if (o == 2'b00) return ST_IDLE;
        if (a)          return ST_AUX_WR;
        return ST_CLR1_RD;
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.state)
            ST_IDLE: if (start) begin
                d.imp = imp_param;
                d.odt = odt_en;
                d.aux = aux_variant;
                if (pre_wait) begin
                    d.state = ST_PRE_POLL;
                end else begin
                    d.state = after_pre(odt_en, aux_variant);
                    d.done  = (odt_en == 2'b00);
                end
            end
            ST_PRE_POLL: begin
                if (flag_seen) begin
                    d.state = after_pre(q.odt, q.aux);
                    d.done  = (q.odt == 2'b00);
                end else if (expired) begin
                    d.state = ST_IDLE;
                    d.err   = 1'b1;
                end
            end
            ST_AUX_WR:  if (reg_ack) d.state = ST_CLR1_RD;
            ST_CLR1_RD: if (reg_ack) begin
                d.rmw   = reg_rdata;
                d.state = ST_CLR1_WR;
            end
            ST_CLR1_WR: if (reg_ack) d.state = use_data ? ST_LOAD_WR : ST_CAL_WR;
            ST_LOAD_WR: if (reg_ack) d.state = ST_CLR2_RD;
            ST_CAL_WR:  if (reg_ack) d.state = ST_CAL_POLL;
            ST_CAL_POLL: begin
                if (flag_seen) begin
                    d.state = ST_CLR2_RD;
                end else if (expired) begin
                    d.state = ST_IDLE;
                    d.err   = 1'b1;
                end
            end
            ST_CLR2_RD: if (reg_ack) begin
                d.rmw   = reg_rdata;
                d.state = ST_CLR2_WR;
            end
            ST_CLR2_WR: if (reg_ack) d.state = ST_IO_WR;
            ST_IO_WR: if (reg_ack) begin
                d.state = ST_IDLE;
                d.done  = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.imp   <= '0;
            q.odt   <= '0;
            q.aux   <= 1'b0;
            q.rmw   <= '0;
            q.done  <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_req   = (q.state != ST_IDLE);
        reg_we    = 1'b0;
        reg_addr  = A_CTRL;
        reg_wdata = '0;
        unique case (q.state)
            ST_PRE_POLL, ST_CAL_POLL: reg_addr = A_STAT;
            ST_AUX_WR: begin
                reg_we    = 1'b1;
                reg_addr  = A_AUX;
                reg_wdata = AUX_WORD;
            end
            ST_CLR1_WR, ST_CLR2_WR: begin
                reg_we    = 1'b1;
                reg_wdata = q.rmw & ~(32'd1 << BIT_CAL);
            end
            ST_LOAD_WR: begin
                reg_we    = 1'b1;
                reg_wdata = load_word;
            end
            ST_CAL_WR: begin
                reg_we    = 1'b1;
                reg_wdata = cal_word;
            end
            ST_IO_WR: begin
                reg_we    = 1'b1;
                reg_addr  = A_IO;
                reg_wdata = {q.odt, 28'd0, q.odt};
            end
            default: ;
        endcase
    end

    assign busy = (q.state != ST_IDLE);
    assign done = q.done;
    assign err  = q.err;
endmodule

// File: rtl/zq_cal_seq_chk.sv
module zq_cal_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_req,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        reg_ack,
    input logic        busy,
    input logic        done,
    input logic        err
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> err || (reg_req && $stable(reg_addr)
                                          && $stable(reg_we) && $stable(reg_wdata))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !reg_req); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err)); // R11

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done)); // R12

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err)); // R11

    AST_IO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == 2'd3) |->
            (reg_wdata[31:30] == reg_wdata[1:0] && reg_wdata[29:2] == 28'd0)); // R11

    AST_AUX_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == 2'd2) |-> reg_wdata == 32'h0100_0002); // R6

    AST_NO_STAT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_addr == 2'd1) |-> !reg_we); // R4
endmodule

bind zq_cal_seq zq_cal_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_req  (reg_req),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_ack  (reg_ack),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/zq_cal_seq_test.sv
`timescale 1ns/1ps
module zq_cal_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] imp_param = '0;
    logic [1:0]  odt_en = '0;
    logic        aux_variant = 1'b0;
    logic        pre_wait = 1'b0;
    logic [15:0] poll_limit = 16'd500;
    logic        reg_req, reg_we, reg_ack;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        busy, done, err;

    always #2 clk = ~clk;

    zq_cal_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .imp_param(imp_param),
        .odt_en(odt_en), .aux_variant(aux_variant), .pre_wait(pre_wait),
        .poll_limit(poll_limit), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata), .busy(busy), .done(done), .err(err)
    );

    // register slave model
    logic        slv_init = 1'b0;
    logic [31:0] init_ctrl = '0;
    logic        init_flag = 1'b1;
    int          init_cnt = 0;
    int          cal_delay = 8;
    logic [31:0] s_ctrl, s_aux, s_io;
    logic        s_flag;
    int          s_cnt;
    logic [1:0]  log_a [0:15];
    logic [31:0] log_d [0:15];
    int          log_n;
    int          done_n;
    int          stat_reads;
    int          first_wr_reads;

    always @(posedge clk) begin
        if (slv_init) begin
            reg_ack <= 1'b0; reg_rdata <= '0;
            s_ctrl <= init_ctrl; s_aux <= '0; s_io <= '0;
            s_flag <= init_flag; s_cnt <= init_cnt;
            log_n <= 0; done_n <= 0; stat_reads <= 0; first_wr_reads <= -1;
        end else begin
            if (done) done_n <= done_n + 1;
            if (s_cnt != 0) begin
                s_cnt <= s_cnt - 1;
                if (s_cnt == 1) s_flag <= 1'b1;
            end
            if (reg_req && !reg_ack) begin
                reg_ack <= 1'b1;
                if (reg_we) begin
                    if (log_n < 16) begin
                        log_a[log_n] <= reg_addr;
                        log_d[log_n] <= reg_wdata;
                    end
                    if (log_n == 0) first_wr_reads <= stat_reads;
                    log_n <= log_n + 1;
                    case (reg_addr)
                        2'd0: begin
                            s_ctrl <= reg_wdata;
                            if (reg_wdata[31]) begin
                                s_flag <= 1'b0;
                                s_cnt  <= cal_delay;
                            end
                        end
                        2'd2: s_aux <= reg_wdata;
                        2'd3: s_io  <= reg_wdata;
                        default: ;
                    endcase
                end else begin
                    case (reg_addr)
                        2'd0: reg_rdata <= s_ctrl;
                        2'd1: begin
                            reg_rdata <= {s_flag, 31'd0};
                            stat_reads <= stat_reads + 1;
                        end
                        2'd2: reg_rdata <= s_aux;
                        default: reg_rdata <= s_io;
                    endcase
                end
            end else begin
                reg_ack <= 1'b0;
            end
        end
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_wr(input string req, input int i, input logic [1:0] a, input logic [31:0] dv);
        chk({req, " addr"}, {30'd0, log_a[i]}, {30'd0, a});
        chk({req, " data"}, log_d[i], dv);
    endtask

    task automatic prep(input logic [31:0] ctrl0, input logic flag0, input int cnt0, input int cdel);
        @(negedge clk);
        init_ctrl = ctrl0; init_flag = flag0; init_cnt = cnt0; cal_delay = cdel;
        slv_init = 1'b1;
        @(negedge clk);
        slv_init = 1'b0;
    endtask

    task automatic kick(input logic [31:0] imp, input logic [1:0] o, input logic av, input logic pw);
        imp_param = imp; odt_en = o; aux_variant = av; pre_wait = pw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output logic got_done, output logic got_err);
        got_done = 1'b0; got_err = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) got_done = 1'b1;
            if (err)  got_err = 1'b1;
            if (got_done || got_err) break;
            @(negedge clk);
        end
    endtask

    // R1
    task automatic t_reset();
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 err",  {31'd0, err},  32'd0);
        chk("R1 req",  {31'd0, reg_req}, 32'd0);
    endtask

    // R4 R7 R8 R10 R11: pre-wait already satisfied, fixed data path
    task automatic t_load();
        logic gd, ge;
        prep(32'h8765_4321, 1'b1, 0, 8);
        kick(32'h0123_4500, 2'b11, 1'b0, 1'b1);
        wait_end(gd, ge);
        chk("R11 done", {31'd0, gd}, 32'd1);
        chk("R11 busy low", {31'd0, busy}, 32'd0);
        chk("R8 writes", log_n, 4);
        chk("R4 status read before writes", first_wr_reads, 1);
        chk_wr("R7 clear", 0, 2'd0, 32'h0765_4321);
        chk_wr("R8 load", 1, 2'd0, 32'h1001_2345);
        chk_wr("R10 clear", 2, 2'd0, 32'h1001_2345);
        chk_wr("R11 io", 3, 2'd3, 32'hC000_0003);
        chk("R8 no poll", stat_reads, 1);
        @(negedge clk);
        chk("R11 done one cycle", {31'd0, done}, 32'd0);
    endtask

    // R6 R9 R10 R11: auxiliary variant, calibration path, high bits ignored
    task automatic t_cal();
        logic gd, ge;
        prep(32'h0000_0000, 1'b1, 0, 10);
        kick(32'hF000_005A, 2'b01, 1'b1, 1'b0);
        chk("R2 busy after start", {31'd0, busy}, 32'd1);
        wait_end(gd, ge);
        chk("R9 done", {31'd0, gd}, 32'd1);
        chk("R9 writes", log_n, 5);
        chk_wr("R6 aux", 0, 2'd2, 32'h0100_0002);
        chk_wr("R7 clear", 1, 2'd0, 32'h0000_0000);
        chk_wr("R9 cal", 2, 2'd0, 32'h85A0_0000);
        chk_wr("R10 clear", 3, 2'd0, 32'h05A0_0000);
        chk_wr("R11 io", 4, 2'd3, 32'h4000_0001);
        chk("R9 polled", {31'd0, (stat_reads >= 2)}, 32'd1);
    endtask

    // R5 R4: termination off, with and without pre-wait
    task automatic t_off();
        logic gd, ge;
        prep(32'h0, 1'b0, 15, 8);
        kick(32'h0000_00FF, 2'b00, 1'b1, 1'b1);
        wait_end(gd, ge);
        chk("R5 done", {31'd0, gd}, 32'd1);
        chk("R5 no err", {31'd0, ge}, 32'd0);
        chk("R5 no writes", log_n, 0);
        chk("R4 waited on flag", {31'd0, (stat_reads >= 2)}, 32'd1);
        prep(32'h0, 1'b1, 0, 8);
        kick(32'h0000_00FF, 2'b00, 1'b0, 1'b0);
        chk("R5 immediate done", {31'd0, done}, 32'd1);
        repeat (4) @(negedge clk);
        chk("R5 no writes immediate", log_n, 0);
    endtask

    // R12: calibration never finishes
    task automatic t_timeout();
        logic gd, ge;
        poll_limit = 16'd20;
        prep(32'hFFFF_FFFF, 1'b1, 0, 100000);
        kick(32'h0000_00FF, 2'b10, 1'b0, 1'b0);
        wait_end(gd, ge);
        chk("R12 err", {31'd0, ge}, 32'd1);
        chk("R12 no done", {31'd0, gd}, 32'd0);
        chk("R12 busy low", {31'd0, busy}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R12 writes stop", log_n, 2);
        chk_wr("R12 clear", 0, 2'd0, 32'h7FFF_FFFF);
        chk_wr("R12 cal", 1, 2'd0, 32'h8FF0_0000);
        poll_limit = 16'd500;
    endtask

    // R2: second start while busy has no effect; data bit 27 alone selects load
    task automatic t_restart();
        logic gd, ge;
        prep(32'h0, 1'b1, 0, 8);
        kick(32'h0800_0000, 2'b10, 1'b0, 1'b0);
        @(negedge clk);
        kick(32'h0000_0011, 2'b01, 1'b1, 1'b0);
        wait_end(gd, ge);
        repeat (5) @(negedge clk);
        chk("R2 done count", done_n, 1);
        chk("R2 writes", log_n, 4);
        chk_wr("R2 load", 1, 2'd0, 32'h1008_0000);
        chk_wr("R2 io", 3, 2'd3, 32'h8000_0002);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        slv_init = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        slv_init = 1'b0;
        t_load();
        t_cal();
        t_off();
        t_timeout();
        t_restart();
        finish_run();
    end
endmodule